// File: doc/BRIEF.md
# Time-Slot Interchanger With Per-Channel Delay Selection

This block moves 8-bit channel samples between time-division streams. Every clock cycle is one channel time: all input streams present the byte for the current channel in parallel, and all output streams leave with the byte for that same channel one cycle later. A connection table, one entry per output stream and channel, names the input stream and channel that feeds each output slot. The entry also holds a delay-mode flag.

Incoming bytes go into a data store split into three frame pages, chosen by the frame count modulo three. With the flag clear, a slot is served with the least possible latency. It reads the page being filled now when its source channel has already passed in this frame, and the page filled in the previous frame otherwise. With the flag set, a slot always reads the page filled two frames earlier. Every channel of a multi-slot wideband connection then sees the same fixed delay and the same frame of origin.

A frame pulse marks channel 0 and restarts the channel count. Without a pulse the count wraps on its own after the last channel. A host side can write and read the connection table and can read, but not write, the data store.

Top module: `tsi_switch`

## Requirements
- R1: Under synchronous active-low reset, every output byte, every connection entry and every stored byte reads zero. The first cycle after reset is channel 0 on page 0.
- R2: A cycle with `frame_sync` high is channel 0 and starts a new frame, even when it comes mid-frame. Otherwise the channel number rises by one per cycle and wraps from NUM_CHAN-1 to 0, which also starts a new frame. Each new frame moves the write page to the next of 0, 1, 2, cyclically.
- R3: In every cycle, the byte of each input stream s is stored at (current page, s, current channel).
- R4: The byte for output stream o occupies `out_data[o*8 +: 8]`, the same layout `in_data` uses for inputs. It is registered and shows the slot of channel c in the cycle after channel c.
- R5: With the mode flag at 0 (variable delay) and source channel below destination channel, the output carries the source byte from the same frame.
- R6: With the mode flag at 0 and source channel equal to or above destination channel, the output carries the source byte from the previous frame.
- R7: With the mode flag at 1 (constant delay), the output carries the source byte from two frames earlier, whatever the channel numbers.
- R8: In variable mode the delay depends only on the source and destination channels. Any input stream may feed any output stream with the same result.
- R9: A connection write (output stream, channel, mode, source stream, source channel) takes effect from the next cycle. The host read port shows the stored entry combinationally.
- R10: The host data-store read returns the byte at (page, stream, channel) combinationally. Page 3 or any out-of-range address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one channel time per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | High in the cycle of channel 0 |
| in_data | input | NUM_IN*8 | Current-channel byte of every input stream |
| out_data | output | NUM_OUT*8 | Switched byte of every output stream, one cycle late |
| cm_wr_en | input | 1 | Connection table write strobe |
| cm_wr_strm | input | log2(NUM_OUT) | Output stream of the written entry |
| cm_wr_chan | input | log2(NUM_CHAN) | Output channel of the written entry |
| cm_wr_mode | input | 1 | 0 variable delay, 1 constant delay |
| cm_wr_src_strm | input | log2(NUM_IN) | Source input stream |
| cm_wr_src_chan | input | log2(NUM_CHAN) | Source channel |
| cm_rd_strm | input | log2(NUM_OUT) | Host read: output stream |
| cm_rd_chan | input | log2(NUM_CHAN) | Host read: output channel |
| cm_rd_mode | output | 1 | Host read: mode flag |
| cm_rd_src_strm | output | log2(NUM_IN) | Host read: source stream |
| cm_rd_src_chan | output | log2(NUM_CHAN) | Host read: source channel |
| dm_rd_page | input | 2 | Host read: data page |
| dm_rd_strm | input | log2(NUM_IN) | Host read: input stream |
| dm_rd_chan | input | log2(NUM_CHAN) | Host read: channel |
| dm_rd_data | output | 8 | Host read: stored byte |

## Verification
The assertions assume that `frame_sync` may arrive in any cycle. The channel and page properties therefore cover both the pulsed restart and the free-running wrap. The page-choice properties take the connection entry as given, with source channels inside the table range. The stimulus writes only in-range connection addresses and sends one pulse per frame, except for a single deliberate mid-frame pulse. Connection rewrites happen while traffic flows, so new entries take effect in the middle of a frame.

// File: rtl/tsi_pkg.sv
// Shared helpers for the time-slot interchanger.
// Assumes: page count fixed at three (constant delay of two frames).
package tsi_pkg;
    localparam int NUM_PAGES = 3;
    localparam int PAGE_W    = 2;

    typedef logic [PAGE_W-1:0] page_t;

    // Index width for a table of n entries, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Next page in the cyclic order 0,1,2.
    function automatic page_t page_next(input page_t p);
        return (p == page_t'(NUM_PAGES - 1)) ? page_t'(0) : page_t'(p + page_t'(1));
    endfunction

    // Previous page in the cyclic order 0,1,2.
    function automatic page_t page_prev(input page_t p);
        return (p == page_t'(0)) ? page_t'(NUM_PAGES - 1) : page_t'(p - page_t'(1));
    endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
// Channel and page sequencer.
// Produces the channel number and write page of the present cycle and the two
// older pages. A frame_sync cycle is channel 0 of a new frame; otherwise the
// count advances and wraps after the last channel.
// Assumes: one channel per clock; reset leaves the sequencer at the last
// channel of page 2 so the first live cycle is channel 0 on page 0.
module tsi_frame_timer
    import tsi_pkg::*;
#(
    parameter int NUM_CHAN = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_sync,
    output logic [idx_w(NUM_CHAN)-1:0]  cur_chan,
    output page_t                       cur_page,
    output page_t                       prev_page,
    output page_t                       old_page
);
    localparam int CW = idx_w(NUM_CHAN);
    localparam logic [CW-1:0] LAST_CHAN = CW'(NUM_CHAN - 1);

    logic [CW-1:0] chan_q;
    page_t         page_q;

    // Decide the channel and page of the present cycle.
    always_comb begin
        if (frame_sync || chan_q == LAST_CHAN) begin
            cur_chan = '0;
            cur_page = page_next(page_q);
        end else begin
            cur_chan = chan_q + CW'(1);
            cur_page = page_q;
        end
        prev_page = page_prev(cur_page);
        old_page  = page_next(cur_page);
    end

    // Remember the present cycle for the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= LAST_CHAN;
            page_q <= page_t'(NUM_PAGES - 1);
        end else begin
            chan_q <= cur_chan;
            page_q <= cur_page;
        end
    end

    p_chan_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chan_q) < NUM_CHAN);

    p_page_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(page_q) < NUM_PAGES);

    p_sync_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (chan_q == '0) && (page_q != $past(page_q)));

    p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && chan_q != LAST_CHAN)
            |=> (chan_q == $past(chan_q) + CW'(1)) && (page_q == $past(page_q)));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && chan_q == LAST_CHAN)
            |=> (chan_q == '0) && (page_q != $past(page_q)));
endmodule

// File: rtl/tsi_conn_mem.sv
// Connection table: one entry per output stream and channel, laid out as
// {mode, source stream, source channel}. Host write and host read ports, plus
// a scan port that presents every output stream's entry for one channel.
// Assumes: out-of-range host writes are dropped, out-of-range reads give zero.
module tsi_conn_mem
    import tsi_pkg::*;
#(
    parameter int NUM_IN   = 4,
    parameter int NUM_OUT  = 4,
    parameter int NUM_CHAN = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [idx_w(NUM_OUT)-1:0]              wr_strm,
    input  logic [idx_w(NUM_CHAN)-1:0]             wr_chan,
    input  logic [idx_w(NUM_IN)+idx_w(NUM_CHAN):0] wr_entry,
    input  logic [idx_w(NUM_OUT)-1:0]              rd_strm,
    input  logic [idx_w(NUM_CHAN)-1:0]             rd_chan,
    output logic [idx_w(NUM_IN)+idx_w(NUM_CHAN):0] rd_entry,
    input  logic [idx_w(NUM_CHAN)-1:0]             scan_chan,
    output logic [NUM_OUT*(idx_w(NUM_IN)+idx_w(NUM_CHAN)+1)-1:0] scan_entries
);
    localparam int CW  = idx_w(NUM_CHAN);
    localparam int SWI = idx_w(NUM_IN);
    localparam int EW  = 1 + SWI + CW;

    logic [EW-1:0] mem [NUM_OUT][NUM_CHAN];
    logic          wr_ok;
    logic          rd_ok;

    // Qualify host addresses against the table size.
    always_comb begin
        wr_ok = wr_en && (int'(wr_strm) < NUM_OUT) && (int'(wr_chan) < NUM_CHAN);
        rd_ok = (int'(rd_strm) < NUM_OUT) && (int'(rd_chan) < NUM_CHAN);
    end

    // Clear the table on reset, otherwise store host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int o = 0; o < NUM_OUT; o++) begin
                for (int c = 0; c < NUM_CHAN; c++) begin
                    mem[o][c] <= '0;
                end
            end
        end else if (wr_ok) begin
            mem[wr_strm][wr_chan] <= wr_entry;
        end
    end

    // Host read of a single entry.
    always_comb begin
        rd_entry = rd_ok ? mem[rd_strm][rd_chan] : '0;
    end

    // Scan read: every output stream at the present channel.
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_scan
        assign scan_entries[o*EW +: EW] = mem[o][scan_chan];
    end

    p_cm_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> mem[$past(wr_strm)][$past(wr_chan)] == $past(wr_entry));
endmodule

// File: rtl/tsi_data_mem.sv
// Paged data store: three frame pages of every input stream and channel.
// All input streams are written each cycle into the live page. One read port
// per output stream and one host read port, all combinational.
// Assumes: write page and channel are always in range (driven by the timer).
module tsi_data_mem
    import tsi_pkg::*;
#(
    parameter int NUM_IN   = 4,
    parameter int NUM_OUT  = 4,
    parameter int NUM_CHAN = 32,
    parameter int DW       = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  page_t                             wr_page,
    input  logic [idx_w(NUM_CHAN)-1:0]        wr_chan,
    input  logic [NUM_IN*DW-1:0]              wr_data,
    input  logic [NUM_OUT*PAGE_W-1:0]         rd_page,
    input  logic [NUM_OUT*idx_w(NUM_IN)-1:0]  rd_strm,
    input  logic [NUM_OUT*idx_w(NUM_CHAN)-1:0] rd_chan,
    output logic [NUM_OUT*DW-1:0]             rd_data,
    input  page_t                             host_page,
    input  logic [idx_w(NUM_IN)-1:0]          host_strm,
    input  logic [idx_w(NUM_CHAN)-1:0]        host_chan,
    output logic [DW-1:0]                     host_data
);
    localparam int CW  = idx_w(NUM_CHAN);
    localparam int SWI = idx_w(NUM_IN);

    logic [DW-1:0] mem [NUM_PAGES][NUM_IN][NUM_CHAN];

    // Clear on reset, otherwise store every input stream in the live page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PAGES; p++) begin
                for (int s = 0; s < NUM_IN; s++) begin
                    for (int c = 0; c < NUM_CHAN; c++) begin
                        mem[p][s][c] <= '0;
                    end
                end
            end
        end else begin
            for (int s = 0; s < NUM_IN; s++) begin
                mem[wr_page][s][wr_chan] <= wr_data[s*DW +: DW];
            end
        end
    end

    // Switch read ports, one per output stream.
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_rd
        page_t           pg;
        logic [SWI-1:0]  st;
        logic [CW-1:0]   ch;
        assign pg = rd_page[o*PAGE_W +: PAGE_W];
        assign st = rd_strm[o*SWI +: SWI];
        assign ch = rd_chan[o*CW +: CW];
        // Fetch the addressed byte, zero when out of range.
        always_comb begin
            if (int'(pg) < NUM_PAGES && int'(st) < NUM_IN && int'(ch) < NUM_CHAN) begin
                rd_data[o*DW +: DW] = mem[pg][st][ch];
            end else begin
                rd_data[o*DW +: DW] = '0;
            end
        end
    end

    // Host read port, zero when out of range.
    always_comb begin
        if (int'(host_page) < NUM_PAGES && int'(host_strm) < NUM_IN
                && int'(host_chan) < NUM_CHAN) begin
            host_data = mem[host_page][host_strm][host_chan];
        end else begin
            host_data = '0;
        end
    end

    for (genvar s = 0; s < NUM_IN; s++) begin : g_wchk
        p_dm_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(wr_page) < NUM_PAGES)
                |=> mem[$past(wr_page)][s][$past(wr_chan)] == $past(wr_data[s*DW +: DW]));
    end
endmodule

// File: rtl/tsi_switch.sv
// Time-slot interchanger top.
// Each cycle stores the present channel of all input streams, looks up every
// output stream's connection entry for that channel, picks a data page from
// the entry's delay mode and source channel, and registers the fetched byte.
// Assumes: one channel per clock, in_data and out_data packed 8 bits per
// stream with stream 0 in the low byte.
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NUM_IN   = 4,
    parameter int NUM_OUT  = 4,
    parameter int NUM_CHAN = 32,
    parameter int DW       = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_sync,
    input  logic [NUM_IN*DW-1:0]         in_data,
    output logic [NUM_OUT*DW-1:0]        out_data,
    input  logic                         cm_wr_en,
    input  logic [idx_w(NUM_OUT)-1:0]    cm_wr_strm,
    input  logic [idx_w(NUM_CHAN)-1:0]   cm_wr_chan,
    input  logic                         cm_wr_mode,
    input  logic [idx_w(NUM_IN)-1:0]     cm_wr_src_strm,
    input  logic [idx_w(NUM_CHAN)-1:0]   cm_wr_src_chan,
    input  logic [idx_w(NUM_OUT)-1:0]    cm_rd_strm,
    input  logic [idx_w(NUM_CHAN)-1:0]   cm_rd_chan,
    output logic                         cm_rd_mode,
    output logic [idx_w(NUM_IN)-1:0]     cm_rd_src_strm,
    output logic [idx_w(NUM_CHAN)-1:0]   cm_rd_src_chan,
    input  logic [PAGE_W-1:0]            dm_rd_page,
    input  logic [idx_w(NUM_IN)-1:0]     dm_rd_strm,
    input  logic [idx_w(NUM_CHAN)-1:0]   dm_rd_chan,
    output logic [DW-1:0]                dm_rd_data
);
    localparam int CW  = idx_w(NUM_CHAN);
    localparam int SWI = idx_w(NUM_IN);
    localparam int EW  = 1 + SWI + CW;

    logic [CW-1:0]               cur_chan;
    page_t                       cur_page;
    page_t                       prev_page;
    page_t                       old_page;
    logic [NUM_OUT*EW-1:0]       scan_entries;
    logic [EW-1:0]               host_entry;
    logic [NUM_OUT*PAGE_W-1:0]   sel_page;
    logic [NUM_OUT*SWI-1:0]      sel_strm;
    logic [NUM_OUT*CW-1:0]       sel_chan;
    logic [NUM_OUT*DW-1:0]       fetched;
    logic [NUM_OUT*DW-1:0]       out_q;

    tsi_frame_timer #(.NUM_CHAN(NUM_CHAN)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .cur_chan   (cur_chan),
        .cur_page   (cur_page),
        .prev_page  (prev_page),
        .old_page   (old_page)
    );

    tsi_conn_mem #(
        .NUM_IN   (NUM_IN),
        .NUM_OUT  (NUM_OUT),
        .NUM_CHAN (NUM_CHAN)
    ) u_cmem (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cm_wr_en),
        .wr_strm      (cm_wr_strm),
        .wr_chan      (cm_wr_chan),
        .wr_entry     ({cm_wr_mode, cm_wr_src_strm, cm_wr_src_chan}),
        .rd_strm      (cm_rd_strm),
        .rd_chan      (cm_rd_chan),
        .rd_entry     (host_entry),
        .scan_chan    (cur_chan),
        .scan_entries (scan_entries)
    );

    // Split the host view of an entry into its fields.
    always_comb begin
        cm_rd_mode     = host_entry[EW-1];
        cm_rd_src_strm = host_entry[CW +: SWI];
        cm_rd_src_chan = host_entry[CW-1:0];
    end

    tsi_data_mem #(
        .NUM_IN   (NUM_IN),
        .NUM_OUT  (NUM_OUT),
        .NUM_CHAN (NUM_CHAN),
        .DW       (DW)
    ) u_dmem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_page   (cur_page),
        .wr_chan   (cur_chan),
        .wr_data   (in_data),
        .rd_page   (sel_page),
        .rd_strm   (sel_strm),
        .rd_chan   (sel_chan),
        .rd_data   (fetched),
        .host_page (dm_rd_page),
        .host_strm (dm_rd_strm),
        .host_chan (dm_rd_chan),
        .host_data (dm_rd_data)
    );

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_sel
        logic          e_mode;
        logic [CW-1:0] e_chan;
        page_t         pg;
        assign e_mode = scan_entries[o*EW + EW - 1];
        assign e_chan = scan_entries[o*EW +: CW];
        assign sel_strm[o*SWI +: SWI] = scan_entries[o*EW + CW +: SWI];
        assign sel_chan[o*CW +: CW]   = e_chan;
        assign sel_page[o*PAGE_W +: PAGE_W] = pg;

        // Choose the page: two frames back, or live/previous by channel order.
        always_comb begin
            if (e_mode) begin
                pg = old_page;
            end else if (e_chan < cur_chan) begin
                pg = cur_page;
            end else begin
                pg = prev_page;
            end
        end

        p_const_not_recent_r7: assert property (@(posedge clk) disable iff (!rst_n)
            e_mode |-> (pg != cur_page) && (pg != prev_page));

        p_live_only_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pg == cur_page) |-> (!e_mode && e_chan < cur_chan));

        p_var_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!e_mode && e_chan >= cur_chan) |-> (pg == prev_page));
    end

    // Register the fetched bytes toward the output streams.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= fetched;
        end
    end

    assign out_data = out_q;
endmodule

// File: tb/sim_tsi_switch.sv
// Bench for tsi_switch: behavioural frame model compared every cycle.
module sim_tsi_switch;
    localparam int NI = 4;
    localparam int NO = 4;
    localparam int NC = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_sync = 1'b0;
    logic [NI*8-1:0] in_data = '0;
    logic [NO*8-1:0] out_data;
    logic          cm_wr_en = 1'b0;
    logic [1:0]    cm_wr_strm = '0;
    logic [4:0]    cm_wr_chan = '0;
    logic          cm_wr_mode = 1'b0;
    logic [1:0]    cm_wr_src_strm = '0;
    logic [4:0]    cm_wr_src_chan = '0;
    logic [1:0]    cm_rd_strm = '0;
    logic [4:0]    cm_rd_chan = '0;
    logic          cm_rd_mode;
    logic [1:0]    cm_rd_src_strm;
    logic [4:0]    cm_rd_src_chan;
    logic [1:0]    dm_rd_page = '0;
    logic [1:0]    dm_rd_strm = '0;
    logic [4:0]    dm_rd_chan = '0;
    logic [7:0]    dm_rd_data;

    int checks = 0;
    int errors = 0;

    tsi_switch #(.NUM_IN(NI), .NUM_OUT(NO), .NUM_CHAN(NC), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .in_data(in_data),
        .out_data(out_data), .cm_wr_en(cm_wr_en), .cm_wr_strm(cm_wr_strm),
        .cm_wr_chan(cm_wr_chan), .cm_wr_mode(cm_wr_mode),
        .cm_wr_src_strm(cm_wr_src_strm), .cm_wr_src_chan(cm_wr_src_chan),
        .cm_rd_strm(cm_rd_strm), .cm_rd_chan(cm_rd_chan), .cm_rd_mode(cm_rd_mode),
        .cm_rd_src_strm(cm_rd_src_strm), .cm_rd_src_chan(cm_rd_src_chan),
        .dm_rd_page(dm_rd_page), .dm_rd_strm(dm_rd_strm), .dm_rd_chan(dm_rd_chan),
        .dm_rd_data(dm_rd_data)
    );

    always #2.5 clk = ~clk;

    // Reference state
    int    mdm [3][NI][NC];
    int    mcm_mode [NO][NC];
    int    mcm_st [NO][NC];
    int    mcm_ch [NO][NC];
    int    mch, mpg;
    int    exp_out [NO];
    string exp_tag [NO];
    bit    model_live = 0;

    // Driver state
    int drv_ch = 0;
    int drv_fr = 0;

    function automatic int byte_of(int fr, int s, int ch);
        return (fr * 29 + s * 71 + ch * 13 + 7) % 256;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model advance at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mch = NC - 1; mpg = 2;
            for (int p = 0; p < 3; p++)
                for (int s = 0; s < NI; s++)
                    for (int c = 0; c < NC; c++) mdm[p][s][c] = 0;
            for (int o = 0; o < NO; o++) begin
                for (int c = 0; c < NC; c++) begin
                    mcm_mode[o][c] = 0; mcm_st[o][c] = 0; mcm_ch[o][c] = 0;
                end
                exp_out[o] = 0; exp_tag[o] = "R1";
            end
            model_live = 1;
        end else begin
            if (frame_sync || mch == NC - 1) begin
                mch = 0; mpg = (mpg + 1) % 3;
            end else begin
                mch++;
            end
            for (int o = 0; o < NO; o++) begin
                int m, st, sc, p;
                m = mcm_mode[o][mch]; st = mcm_st[o][mch]; sc = mcm_ch[o][mch];
                if (m == 1) begin
                    p = (mpg + 1) % 3; exp_tag[o] = "R4,R7";
                end else if (sc < mch) begin
                    p = mpg; exp_tag[o] = (st != o) ? "R4,R5,R8" : "R4,R5";
                end else begin
                    p = (mpg + 2) % 3; exp_tag[o] = (st != o) ? "R4,R6,R8" : "R4,R6";
                end
                exp_out[o] = mdm[p][st][sc];
            end
            for (int s = 0; s < NI; s++) mdm[mpg][s][mch] = int'(in_data[s*8 +: 8]);
            if (cm_wr_en) begin
                mcm_mode[cm_wr_strm][cm_wr_chan] = int'(cm_wr_mode);
                mcm_st[cm_wr_strm][cm_wr_chan]   = int'(cm_wr_src_strm);
                mcm_ch[cm_wr_strm][cm_wr_chan]   = int'(cm_wr_src_chan);
            end
        end
    end

    // Compare every output stream away from the rising edge
    always @(negedge clk) begin
        if (model_live) begin
            for (int o = 0; o < NO; o++) check(exp_tag[o], int'(out_data[o*8 +: 8]), exp_out[o]);
        end
    end

    // One channel time of stimulus, optionally with a connection write
    task automatic step(bit force_sync, bit we, int o, int c, int m, int ss, int sc);
        @(negedge clk);
        if (force_sync && drv_ch != 0) begin
            drv_ch = 0; drv_fr++;
        end
        frame_sync = (drv_ch == 0);
        for (int s = 0; s < NI; s++) in_data[s*8 +: 8] = 8'(byte_of(drv_fr, s, drv_ch));
        cm_wr_en = we;
        cm_wr_strm = 2'(o); cm_wr_chan = 5'(c); cm_wr_mode = m[0];
        cm_wr_src_strm = 2'(ss); cm_wr_src_chan = 5'(sc);
        drv_ch++;
        if (drv_ch == NC) begin
            drv_ch = 0; drv_fr++;
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic dm_probe(string tag, int p, int s, int c);
        dm_rd_page = 2'(p); dm_rd_strm = 2'(s); dm_rd_chan = 5'(c);
        #0.5;
        check(tag, int'(dm_rd_data), (p < 3) ? mdm[p][s][c] : 0);
    endtask

    task automatic cm_probe(int o, int c);
        cm_rd_strm = 2'(o); cm_rd_chan = 5'(c);
        #0.5;
        check("R9 mode", int'(cm_rd_mode), mcm_mode[o][c]);
        check("R9 src stream", int'(cm_rd_src_strm), mcm_st[o][c]);
        check("R9 src chan", int'(cm_rd_src_chan), mcm_ch[o][c]);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        check("R1 out", int'(out_data), 0);
        cm_probe(2, 9);
        dm_probe("R1 store", 1, 3, 17);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        dm_probe("R1 first cycle page0 chan0", 0, 1, 0);
        drv_ch = 1;  // one step consumed above; keep driver aligned
        // R9: fill the table while traffic flows, mixed modes, cross streams
        for (int o = 0; o < NO; o++)
            for (int c = 0; c < NC; c++)
                step(0, 1, o, c, (c % 3 == 0) ? 1 : 0, (o + 1) % NI, (c * 7 + 3) % NC);
        @(negedge clk);
        cm_probe(0, 0); cm_probe(3, 31); cm_probe(1, 14);
        run(6 * NC);
        // R2: mid-frame pulse restarts the count and moves to the next page
        run(10);
        step(1, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        for (int s = 0; s < NI; s++) dm_probe("R2 R3 restart", mpg, s, 0);
        run(3 * NC);
        // R7: every slot in constant mode
        for (int o = 0; o < NO; o++)
            for (int c = 0; c < NC; c++) step(0, 1, o, c, 1, (o + 2) % NI, (c + 5) % NC);
        run(3 * NC);
        // R6 equal channels, R5/R6 neighbours, variable mode
        for (int o = 0; o < NO; o++)
            for (int c = 0; c < NC; c++)
                step(0, 1, o, c, 0, NI - 1 - o, (o % 2 == 0) ? c : (c + NC - 1) % NC);
        run(3 * NC);
        // R10: host reads of the store, including the unused page code
        @(negedge clk);
        dm_probe("R10", 0, 2, 5);
        dm_probe("R10", 1, 0, 31);
        dm_probe("R10", 2, 3, 12);
        dm_probe("R10 page3", 3, 1, 4);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule